// File: doc/BRIEF.md
# Indirect-Window Register File

This block is the file-register store of a small 8-bit controller datapath. A 5-bit file address picks one of 31 byte-wide locations at 01h to 1Fh. Location 00h holds no data. Any access to it is redirected to the location named by the low five bits of a pointer register that lives at 04h. This gives the datapath a way to walk through a table using a pointer it can compute.

A few low locations have fixed roles. 01h holds the timer/counter byte, 04h holds the pointer, and 05h to 09h hold five port data bytes. These values are also driven out on side ports. The program-counter low byte (02h) and the status byte (03h) are kept by their own blocks. A write that resolves to either of them does not change storage here. Instead it raises a one-cycle strobe and presents the data, and a read of either location returns the value its owner supplies on an input. Locations 0Ah to 1Fh are general-purpose bytes.

A write is committed on the rising clock edge when the write enable is high. A read is combinational from the resolved address.

Top module: `rfi_regfile`

## Requirements
- R1: With `faddr` in 0Ah..1Fh and `wr_en` high, the byte on `wdata` is stored at that address on the rising edge. From then on, `rdata` returns it whenever `faddr` selects that address.
- R2: While `rst_n` is low, every stored location is cleared to 00h. After reset, `fsel_q`, `tmr_q` and all of `port_q` are 00h, and a read of any stored address returns 00h.
- R3: A read with `faddr` = 00h returns the contents of the location whose address equals bits 4:0 of the pointer (04h). This includes the externally owned 02h and 03h.
- R4: A write with `faddr` = 00h goes to the location addressed by bits 4:0 of the pointer.
- R5: Pointer bits 7:5 are stored and appear on `fsel_q`, but they take no part in choosing the effective address.
- R6: When `faddr` = 00h and pointer bits 4:0 are also 00000, `rdata` is 00h, and a write changes no stored location and raises no strobe.
- R7: A write that resolves to 02h raises `pcl_wr`, and one that resolves to 03h raises `stat_wr`. Each strobe is high only during that cycle while `wr_en` is high, `side_wdata` carries the data, and no stored location changes. Reads of 02h and 03h return `pcl_in` and `stat_in`.
- R8: `tmr_q` shows location 01h and `fsel_q` shows 04h. `port_q` shows the port bytes 05h..09h, with location 05h+k at bits 8k+7:8k. Each side port updates on the edge that writes its location.
- R9: While `wr_en` is low, no stored location changes and neither strobe rises, whatever `faddr` and `wdata` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| faddr | input | 5 | File address; 00h selects the indirect window |
| wr_en | input | 1 | Write enable |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data from the resolved address |
| pcl_in | input | 8 | Current program-counter low byte from its owner |
| stat_in | input | 8 | Current status byte from its owner |
| pcl_wr | output | 1 | Write strobe for location 02h |
| stat_wr | output | 1 | Write strobe for location 03h |
| side_wdata | output | 8 | Data that goes with either strobe |
| tmr_q | output | 8 | Timer/counter byte (01h) |
| fsel_q | output | 8 | Pointer byte (04h) |
| port_q | output | 40 | Port bytes 05h..09h, byte k = location 05h+k |

## Verification
The pointer drives every access to 00h, so a pointer that resolves wrongly, for example one that also decodes bits 7:5, appears on `rdata` at the first indirect read. A corrupted stored byte appears at the first read of its address, or at once on a side port for 01h and 04h..09h. A write that escapes the null window or the externally owned slots shows up only when the disturbed location is read back later. For that reason the bench re-reads the whole file after each such write.

// File: rtl/rfi_pkg.sv
package rfi_pkg;
  localparam int DW      = 8;
  localparam int AW      = 5;
  localparam int NLOC    = 1 << AW;
  localparam int N_PORTS = 5;

  typedef logic [AW-1:0] faddr_t;
  typedef logic [DW-1:0] byte_t;

  localparam faddr_t A_WIN   = faddr_t'(0);
  localparam faddr_t A_TMR   = faddr_t'(1);
  localparam faddr_t A_PCL   = faddr_t'(2);
  localparam faddr_t A_STAT  = faddr_t'(3);
  localparam faddr_t A_PTR   = faddr_t'(4);
  localparam faddr_t A_PORT0 = faddr_t'(5);

  function automatic faddr_t resolve_addr(faddr_t a, faddr_t ptr_lo);
    return (a == A_WIN) ? ptr_lo : a;
  endfunction

  function automatic logic is_external(faddr_t a);
    return (a == A_PCL) || (a == A_STAT);
  endfunction
endpackage

// File: rtl/rfi_resolve.sv
module rfi_resolve
  import rfi_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  faddr_t faddr,
  input  faddr_t ptr_lo,
  input  logic   wr_en,
  output faddr_t eff_addr,
  output logic   null_hit,
  output logic   store_we,
  output logic   pcl_wr,
  output logic   stat_wr
);
  always_comb begin
    eff_addr = resolve_addr(faddr, ptr_lo);
    null_hit = (eff_addr == A_WIN);
    store_we = wr_en && !null_hit && !is_external(eff_addr);
    pcl_wr   = wr_en && (eff_addr == A_PCL);
    stat_wr  = wr_en && (eff_addr == A_STAT);
  end

  p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pcl_wr, stat_wr, store_we}));
  p_null_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    null_hit |-> !(pcl_wr || stat_wr || store_we));
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> !(pcl_wr || stat_wr || store_we));
endmodule

// File: rtl/rfi_store.sv
module rfi_store
  import rfi_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  faddr_t               addr,
  input  byte_t                wdata,
  input  byte_t                pcl_in,
  input  byte_t                stat_in,
  output byte_t                rdata,
  output byte_t                tmr_q,
  output byte_t                fsel_q,
  output logic [N_PORTS*DW-1:0] port_q
);
  byte_t              loc [NLOC];
  logic [NLOC*DW-1:0] flat;

  for (genvar i = 0; i < NLOC; i++) begin : g_loc
    if (i == int'(A_WIN) || is_external(faddr_t'(i))) begin : g_hole
      assign loc[i] = '0;
    end else begin : g_reg
      byte_t q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        q <= '0;
        else if (we && addr == faddr_t'(i)) q <= wdata;
      end
      assign loc[i] = q;
    end
    assign flat[i*DW +: DW] = loc[i];
  end

  for (genvar k = 0; k < N_PORTS; k++) begin : g_port
    assign port_q[k*DW +: DW] = loc[int'(A_PORT0) + k];
  end

  assign tmr_q  = loc[A_TMR];
  assign fsel_q = loc[A_PTR];

  always_comb begin
    unique case (addr)
      A_WIN:   rdata = '0;
      A_PCL:   rdata = pcl_in;
      A_STAT:  rdata = stat_in;
      default: rdata = loc[addr];
    endcase
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(flat));
  p_write_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr > A_PORT0 + faddr_t'(N_PORTS - 1)) |=> flat[$past(addr)*DW +: DW] == $past(wdata));
endmodule

// File: rtl/rfi_regfile.sv
module rfi_regfile
  import rfi_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [AW-1:0]           faddr,
  input  logic                    wr_en,
  input  logic [DW-1:0]           wdata,
  output logic [DW-1:0]           rdata,
  input  logic [DW-1:0]           pcl_in,
  input  logic [DW-1:0]           stat_in,
  output logic                    pcl_wr,
  output logic                    stat_wr,
  output logic [DW-1:0]           side_wdata,
  output logic [DW-1:0]           tmr_q,
  output logic [DW-1:0]           fsel_q,
  output logic [N_PORTS*DW-1:0]   port_q
);
  faddr_t eff_addr;
  logic   null_hit;
  logic   store_we;

  rfi_resolve u_resolve (
    .clk      (clk),
    .rst_n    (rst_n),
    .faddr    (faddr),
    .ptr_lo   (fsel_q[AW-1:0]),
    .wr_en    (wr_en),
    .eff_addr (eff_addr),
    .null_hit (null_hit),
    .store_we (store_we),
    .pcl_wr   (pcl_wr),
    .stat_wr  (stat_wr)
  );

  rfi_store u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (store_we),
    .addr    (eff_addr),
    .wdata   (wdata),
    .pcl_in  (pcl_in),
    .stat_in (stat_in),
    .rdata   (rdata),
    .tmr_q   (tmr_q),
    .fsel_q  (fsel_q),
    .port_q  (port_q)
  );

  assign side_wdata = wdata;

  p_null_reads_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (faddr == A_WIN && fsel_q[AW-1:0] == A_WIN) |-> rdata == '0);
  p_ptr_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (faddr == A_PTR || (faddr == A_WIN && fsel_q[AW-1:0] == A_PTR)))
      |=> fsel_q == $past(wdata));
  p_window_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (faddr == A_WIN && fsel_q[AW-1:0] == A_PCL) |-> rdata == pcl_in);
endmodule

// File: tb/rfi_regfile_tb.sv
module rfi_regfile_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  faddr = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  pcl_in = 8'hA5;
  logic [7:0]  stat_in = 8'h3C;
  logic [7:0]  rdata, side_wdata, tmr_q, fsel_q;
  logic        pcl_wr, stat_wr;
  logic [39:0] port_q;

  int tests = 0;
  int fails = 0;
  logic [7:0] model [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  rfi_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .faddr(faddr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .pcl_in(pcl_in), .stat_in(stat_in), .pcl_wr(pcl_wr),
    .stat_wr(stat_wr), .side_wdata(side_wdata), .tmr_q(tmr_q),
    .fsel_q(fsel_q), .port_q(port_q)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] eff(logic [4:0] a);
    return (a == 5'd0) ? model[4][4:0] : a;
  endfunction

  function automatic logic [7:0] exp_read(logic [4:0] a);
    logic [4:0] e = eff(a);
    if (e == 5'd0) return 8'h00;
    if (e == 5'd2) return pcl_in;
    if (e == 5'd3) return stat_in;
    return model[e];
  endfunction

  // Drive at negedge, check strobes, commit at posedge, update model.
  task automatic wr(string req, logic [4:0] a, logic [7:0] d);
    logic [4:0] e;
    @(negedge clk);
    faddr = a; wdata = d; wr_en = 1'b1;
    #1;
    e = eff(a);
    check({req, " pcl_wr"}, pcl_wr, e == 5'd2);
    check({req, " stat_wr"}, stat_wr, e == 5'd3);
    if (e == 5'd2 || e == 5'd3) check({req, " side_wdata"}, side_wdata, d);
    @(posedge clk);
    if (e != 5'd0 && e != 5'd2 && e != 5'd3) model[e] = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(string req, logic [4:0] a);
    @(negedge clk);
    faddr = a;
    #1;
    check(req, rdata, exp_read(a));
  endtask

  task automatic sweep_all(string req);
    for (int a = 1; a < 32; a++) rd(req, 5'(a));
    check({req, " side"}, {tmr_q, fsel_q, port_q},
          {model[1], model[4], model[9], model[8], model[7], model[6], model[5]});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R2 reset state
    sweep_all("R2 reset");
    rd("R2 window after reset", 5'd0);

    // R1 direct writes over general-purpose space
    for (int a = 10; a < 32; a++) wr("R1 write", 5'(a), 8'(a * 7 + 3));
    sweep_all("R1 readback");

    // R8 side registers
    wr("R8 tmr", 5'd1, 8'h5A);
    for (int k = 0; k < 5; k++) wr("R8 port", 5'(5 + k), 8'(8'h11 * (k + 1)));
    wr("R8 ptr", 5'd4, 8'h0C);
    check("R8 tmr_q", tmr_q, 8'h5A);
    check("R8 fsel_q", fsel_q, 8'h0C);
    check("R8 port_q", port_q, 40'h5544332211);

    // R3/R5 indirect reads with every pointer value, junk in bits 7:5
    for (int p = 0; p < 32; p++) begin
      wr("R5 ptr load", 5'd4, 8'((p * 37 & 8'hE0) | p));
      check("R5 fsel_q keeps upper bits", fsel_q, 8'((p * 37 & 8'hE0) | p));
      rd("R3 window read", 5'd0);
    end

    // R4 indirect writes
    for (int p = 10; p < 32; p += 3) begin
      wr("R4 ptr", 5'd4, 8'(8'hE0 | p));
      wr("R4 window write", 5'd0, 8'(p ^ 8'h96));
      rd("R4 direct readback", 5'(p));
    end
    wr("R4 ptr to port", 5'd4, 8'h07);
    wr("R4 window port", 5'd0, 8'hC3);
    check("R4 port C via window", port_q[23:16], 8'hC3);

    // R6 null pointer
    wr("R6 ptr", 5'd4, 8'hA0);
    rd("R6 null read", 5'd0);
    check("R6 null read is zero", rdata, 8'h00);
    wr("R6 null write", 5'd0, 8'hFF);
    sweep_all("R6 no change");

    // R7 externally owned locations, direct and indirect
    wr("R7 pcl direct", 5'd2, 8'h42);
    wr("R7 stat direct", 5'd3, 8'h24);
    wr("R7 ptr", 5'd4, 8'h03);
    wr("R7 stat window", 5'd0, 8'h99);
    pcl_in = 8'h6E; stat_in = 8'hE6;
    rd("R7 pcl read", 5'd2);
    rd("R7 stat read", 5'd3);
    rd("R7 window stat read", 5'd0);
    @(negedge clk);
    check("R7 strobe one cycle", {pcl_wr, stat_wr}, 2'b00);
    sweep_all("R7 no store change");

    // R9 writes with enable low
    for (int a = 0; a < 32; a++) begin
      @(negedge clk);
      faddr = 5'(a); wdata = 8'hEE; wr_en = 1'b0;
      #1;
      check("R9 no strobe", {pcl_wr, stat_wr}, 2'b00);
      @(posedge clk);
    end
    sweep_all("R9 unchanged");

    // R2 second reset
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 32; i++) model[i] = 8'h00;
    #1;
    check("R2 async clear", {tmr_q, fsel_q, port_q}, 56'h0);
    @(negedge clk);
    rst_n = 1'b1;
    sweep_all("R2 reset again");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule